// File: doc/BRIEF.md
# Daisy-chain serial control-word router

This block is the digital serial slave of a converter device that can sit in a chain of up to eight identical devices on one serial port. It takes 16-bit words MSB first on a serial data line. A frame-sync pulse marks the first bit of each word. After every received word it sends exactly one 16-bit word out on its own serial output. That output feeds the next device in the chain, or the host at the end of the chain.

Each control word carries a three-bit hop count. When the count is not zero, the word is not for this device. It leaves again with the count reduced by one and has no local effect. When the count is zero, the word writes or reads one of the local 8-bit registers. Register 0 selects the operating mode: program, data or mixed, plus two loop-back diagnostics. Sample words go to the converter data output. Each outgoing frame that no other rule claims carries the converter input sample. A serial-enable input lets the chain be stopped and restarted without losing its configuration.

Top module: `word_router`

## Requirements
- R1: While rst_ni is low, and right after it rises, all registers read back as zero, the block is in program mode, and sdofs_o, sdo_o, dac_vld_o and dac_data_o are all 0.
- R2: A word starts on the clock where sdifs_i is high, and that clock samples its MSB. Its LSB is sampled 15 clocks later. Two clock cycles after that, sdofs_o is high for exactly one cycle, and the output word is shifted out MSB first, one bit per clock, starting in that same cycle.
- R3: Field layout of a word: bit 15 is the kind (1 means control in mixed mode), bit 14 selects read (1) or write (0), bits 13:11 hold the hop count, bits 10:8 select the register, and bits 7:0 hold the data.
- R4: A control word with a nonzero hop count goes out in the next output frame with its hop count reduced by one and all other bits unchanged. It writes no register.
- R5: A write control word with hop count 0 stores bits 7:0 into the selected register. A write to a select value of 6 or 7 (no register there) has no effect. The output frame then carries adc_data_i.
- R6: A read control word with hop count 0 is answered in the next output frame by {1, 1, 000, select, register value}. A select with no register reads as 0.
- R7: Register 0 holds the mode: bit 0 selects data operation, bit 1 selects mixed operation, bit 2 selects serial-port loop-back, and bit 3 selects digital loop-back. With bit 0 clear (program mode), every word is a control word whatever its bit 15.
- R8: In data mode (bit 0 set, bit 1 clear), every word is a sample. dac_data_o takes the word, and dac_vld_o is high for one cycle; both appear in the cycle where sdofs_o rises. The output frame carries adc_data_i.
- R9: In mixed mode (bits 0 and 1 set), bit 15 of the word picks control (1) or sample (0).
- R10: With digital loop-back set, the output frame for a sample word is that same sample word instead of adc_data_i.
- R11: With serial-port loop-back set, every output frame repeats the received word unchanged. The local effects of the word (writes, samples) still take place.
- R12: While se_i is low, no register changes and sdofs_o stays 0. A word in progress is dropped, and a word sent while se_i is low is ignored. After se_i rises, the register values are kept and the next framed word is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| se_i | input | 1 | Serial enable; low freezes the port |
| sdi_i | input | 1 | Serial data in, MSB first |
| sdifs_i | input | 1 | Input frame sync, high with the MSB |
| adc_data_i | input | 16 | Converter sample to send out |
| sdo_o | output | 1 | Serial data out, MSB first |
| sdofs_o | output | 1 | Output frame sync, high with the MSB |
| dac_data_o | output | 16 | Last sample word received |
| dac_vld_o | output | 1 | One-cycle strobe for dac_data_o |

## Verification
Every result of a word lands in a single, known cycle: the clock that samples the LSB, then one clock to decode and load. So sdofs_o, the first output bit, dac_vld_o and dac_data_o are all due two cycles after the LSB is driven, and the remaining output bits follow one per clock. The bench drives inputs and samples outputs on falling edges. It checks that sdofs_o is still low one cycle after the LSB and high the next cycle. In that same cycle it checks the converter outputs, then collects the 16 output bits. It compares them with a word predicted by a bench model of the register file and mode bits. Serial-enable cases are checked cycle by cycle while se_i is low, then through read-back after it rises.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  typedef enum logic [1:0] {
    SRC_ADC  = 2'd0,
    SRC_FWD  = 2'd1,
    SRC_READ = 2'd2,
    SRC_RAW  = 2'd3
  } out_src_e;

  // mode bits in register 0
  localparam int unsigned MD_DATA  = 0;
  localparam int unsigned MD_MIXED = 1;
  localparam int unsigned MD_PLB   = 2;
  localparam int unsigned MD_DLB   = 3;
endpackage

// File: rtl/ser_rx.sv
module ser_rx #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sd_i,
  input  logic         fs_i,
  output logic [W-1:0] word_o,
  output logic         vld_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-2:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      vld_o  <= 1'b0;
      word_o <= '0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (!busy_q) begin
        if (fs_i) begin
          sh_q   <= {sh_q[W-3:0], sd_i};
          busy_q <= 1'b1;
          cnt_q  <= CW'(1);
        end
      end else begin
        sh_q <= {sh_q[W-3:0], sd_i};
        if (cnt_q == CW'(W-1)) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          vld_o  <= 1'b1;
          word_o <= {sh_q, sd_i};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         sd_o,
  output logic         fs_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      fs_o  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      fs_o  <= 1'b0;
    end else begin
      fs_o <= load_i;
      if (load_i) begin
        sh_q  <= word_i;
        cnt_q <= CW'(W-1);
        act_q <= 1'b1;
      end else if (act_q) begin
        sh_q <= {sh_q[W-2:0], 1'b0};
        if (cnt_q == '0) act_q <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign sd_o = act_q & sh_q[W-1];
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [SEL_W-1:0]                 sel_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs_o[g] <= '0;
      else if (we_i && sel_i == SEL_W'(g)) regs_o[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel_i == SEL_W'(i)) rdata_o = regs_o[i];
  end
endmodule

// File: rtl/word_router.sv
module word_router
  import ctl_pkg::*;
#(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned HOP_W    = 3,
  parameter int unsigned NUM_REGS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              se_i,
  input  logic              sdi_i,
  input  logic              sdifs_i,
  input  logic [WORD_W-1:0] adc_data_i,
  output logic              sdo_o,
  output logic              sdofs_o,
  output logic [WORD_W-1:0] dac_data_o,
  output logic              dac_vld_o
);
  localparam int unsigned SEL_LSB  = DATA_W;
  localparam int unsigned HOP_LSB  = DATA_W + SEL_W;
  localparam int unsigned RW_BIT   = HOP_LSB + HOP_W;
  localparam int unsigned KIND_BIT = RW_BIT + 1;

  logic [WORD_W-1:0]               rx_word;
  logic                            rx_vld;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [DATA_W-1:0]               rd_data;
  logic [HOP_W-1:0]                hop;
  logic [SEL_W-1:0]                sel;
  logic                            kind, rw, hop_nz, is_ctrl, go, wr_en;
  logic                            md_data, md_mixed, md_plb, md_dlb;
  out_src_e                        src;
  logic [WORD_W-1:0]               out_word;

  ser_rx #(.W(WORD_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (se_i),
    .sd_i   (sdi_i),
    .fs_i   (sdifs_i),
    .word_o (rx_word),
    .vld_o  (rx_vld)
  );

  assign hop    = rx_word[HOP_LSB +: HOP_W];
  assign sel    = rx_word[SEL_LSB +: SEL_W];
  assign kind   = rx_word[KIND_BIT];
  assign rw     = rx_word[RW_BIT];
  assign hop_nz = |hop;

  assign md_data  = regs_q[0][MD_DATA];
  assign md_mixed = regs_q[0][MD_MIXED];
  assign md_plb   = regs_q[0][MD_PLB];
  assign md_dlb   = regs_q[0][MD_DLB];

  // program mode: everything is control; mixed: bit 15 decides
  assign is_ctrl = !md_data || (md_mixed && kind);
  assign go      = rx_vld && se_i;
  assign wr_en   = go && is_ctrl && !hop_nz && !rw;

  reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .sel_i   (sel),
    .wdata_i (rx_word[DATA_W-1:0]),
    .rdata_o (rd_data),
    .regs_o  (regs_q)
  );

  always_comb begin
    if (md_plb)                   src = SRC_RAW;
    else if (is_ctrl && hop_nz)   src = SRC_FWD;
    else if (is_ctrl && rw)       src = SRC_READ;
    else if (!is_ctrl && md_dlb)  src = SRC_RAW;
    else                          src = SRC_ADC;
  end

  always_comb begin
    unique case (src)
      SRC_FWD:  out_word = {kind, rw, hop - 1'b1, rx_word[HOP_LSB-1:0]};
      SRC_READ: out_word = {2'b11, {HOP_W{1'b0}}, sel, rd_data};
      SRC_RAW:  out_word = rx_word;
      default:  out_word = adc_data_i;
    endcase
  end

  ser_tx #(.W(WORD_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (se_i),
    .load_i (go),
    .word_i (out_word),
    .sd_o   (sdo_o),
    .fs_o   (sdofs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_data_o <= '0;
      dac_vld_o  <= 1'b0;
    end else begin
      dac_vld_o <= go && !is_ctrl;
      if (go && !is_ctrl) dac_data_o <= rx_word;
    end
  end
endmodule

// File: rtl/word_router_chk.sv
module word_router_chk #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned DATA_W   = 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            se_i,
  input logic                            sdofs_o,
  input logic                            dac_vld_o,
  input logic                            rx_vld,
  input logic                            is_ctrl,
  input logic                            hop_nz,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
  AST_FS_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdofs_o |=> !sdofs_o); // R2
  AST_FRAME_FOLLOWS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld && se_i) |=> sdofs_o); // R2
  AST_FWD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld && is_ctrl && hop_nz) |=> $stable(regs)); // R4
  AST_CTRL_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld && is_ctrl) |=> !dac_vld_o); // R7
  AST_SAMPLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld && se_i && !is_ctrl) |=> dac_vld_o); // R8
  AST_SE_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !se_i |=> !sdofs_o); // R12
  AST_SE_REGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !se_i |=> $stable(regs)); // R12
endmodule

bind word_router word_router_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .se_i      (se_i),
  .sdofs_o   (sdofs_o),
  .dac_vld_o (dac_vld_o),
  .rx_vld    (rx_vld),
  .is_ctrl   (is_ctrl),
  .hop_nz    (hop_nz),
  .regs      (regs_q)
);

// File: tb/tb_word_router.sv
`timescale 1ns/1ps
module tb_word_router;
  localparam int N_REGS = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        se_i = 1'b1;
  logic        sdi_i = 1'b0;
  logic        sdifs_i = 1'b0;
  logic [15:0] adc_data_i = '0;
  logic        sdo_o, sdofs_o, dac_vld_o;
  logic [15:0] dac_data_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [7:0]  m_regs [8];
  logic [15:0] exp_dac;

  always #5 clk_i = ~clk_i;

  word_router dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .se_i(se_i), .sdi_i(sdi_i), .sdifs_i(sdifs_i),
    .adc_data_i(adc_data_i), .sdo_o(sdo_o), .sdofs_o(sdofs_o),
    .dac_data_o(dac_data_o), .dac_vld_o(dac_vld_o)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input bit kind, input bit rd, input int hop, input int sel, input logic [7:0] d);
    return {kind, rd, 3'(hop), 3'(sel), d};
  endfunction

  // bench model of the block's response to one word
  task automatic model(input logic [15:0] w, input logic [15:0] adc, output logic [15:0] eo, output bit ev);
    bit ctrl, plb, dlb;
    logic [2:0] hop, sel;
    logic [7:0] rv;
    ctrl = !m_regs[0][0] || (m_regs[0][1] && w[15]);
    plb = m_regs[0][2];
    dlb = m_regs[0][3];
    hop = w[13:11];
    sel = w[10:8];
    rv = (int'(sel) < N_REGS) ? m_regs[sel] : 8'h00;
    ev = 0;
    if (ctrl) begin
      if (hop != 0)  eo = {w[15], w[14], hop - 3'd1, w[10:0]};
      else if (w[14]) eo = {2'b11, 3'b000, sel, rv};
      else begin
        eo = adc;
        if (int'(sel) < N_REGS) m_regs[sel] = w[7:0];
      end
    end else begin
      ev = 1;
      exp_dac = w;
      eo = dlb ? w : adc;
    end
    if (plb) eo = w;
  endtask

  task automatic send(input logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      sdifs_i = (i == 0);
      sdi_i = w[15-i];
    end
  endtask

  task automatic xfer(input logic [15:0] w, input string req);
    logic [15:0] eo, got;
    bit ev;
    adc_data_i = 16'($urandom);
    model(w, adc_data_i, eo, ev);
    send(w);
    @(negedge clk_i);
    sdifs_i = 0; sdi_i = 0;
    check(sdofs_o == 1'b0, {"R2 early sync ", req}, 16'(sdofs_o), 16'd0);
    @(negedge clk_i);
    check(sdofs_o == 1'b1, {"R2 sync slot ", req}, 16'(sdofs_o), 16'd1);
    check(dac_vld_o == ev, {"R8 dac strobe ", req}, 16'(dac_vld_o), 16'(ev));
    check(dac_data_o == exp_dac, {"R8 dac data ", req}, dac_data_o, exp_dac);
    got[15] = sdo_o;
    for (int i = 1; i < 16; i++) begin
      @(negedge clk_i);
      if (i == 1) check(sdofs_o == 1'b0, {"R2 sync width ", req}, 16'(sdofs_o), 16'd0);
      got[15-i] = sdo_o;
    end
    check(got == eo, req, got, eo);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    sdifs_i = 0; sdi_i = 0; se_i = 1;
    repeat (3) @(negedge clk_i);
    check(sdofs_o == 0 && sdo_o == 0, "R1 serial out idle", {14'd0, sdofs_o, sdo_o}, 16'd0);
    check(dac_vld_o == 0 && dac_data_o == 0, "R1 dac cleared", dac_data_o, 16'd0);
    foreach (m_regs[i]) m_regs[i] = 8'h00;
    exp_dac = '0;
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  initial begin
    #(10ns * 100000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    for (int s = 0; s < 8; s++) xfer(cw(1, 1, 0, s, 8'h00), "R1 R6 reset read");

    // directed program-mode cases
    xfer(cw(1, 0, 0, 1, 8'hA5), "R5 write reg1");
    xfer(cw(1, 1, 0, 1, 8'h00), "R6 read reg1");
    xfer(cw(1, 0, 0, 7, 8'h77), "R5 write absent reg");
    xfer(cw(1, 1, 0, 7, 8'h00), "R6 read absent reg");
    xfer(cw(1, 0, 7, 1, 8'h3C), "R4 forward hop 7");
    xfer(cw(0, 1, 1, 2, 8'h11), "R4 forward hop 1");
    xfer(cw(1, 1, 0, 1, 8'h00), "R4 forwarded write left reg1");
    xfer(cw(0, 0, 0, 2, 8'hC3), "R7 bit15 clear still control");
    xfer(cw(0, 1, 0, 2, 8'h00), "R7 R3 read back reg2");

    // random control traffic in program mode
    for (int n = 0; n < 60; n++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (w[13:11] == 0 && !w[14] && w[10:8] == 0) w[3:0] = 4'h0;
      xfer(w, "R3 R4 R5 R6 random control");
    end

    // serial-enable freeze
    xfer(cw(1, 0, 0, 2, 8'h5A), "R12 setup write");
    for (int i = 0; i < 7; i++) begin
      @(negedge clk_i);
      sdifs_i = (i == 0);
      sdi_i = 1'b1;
    end
    @(negedge clk_i);
    se_i = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      sdifs_i = 1'($urandom); sdi_i = 1'($urandom);
      check(sdofs_o == 0, "R12 no frame while disabled", 16'(sdofs_o), 16'd0);
    end
    send(cw(1, 0, 0, 2, 8'hFF));
    @(negedge clk_i);
    sdifs_i = 0;
    check(sdofs_o == 0, "R12 ignored word gives no frame", 16'(sdofs_o), 16'd0);
    se_i = 1;
    @(negedge clk_i);
    xfer(cw(1, 1, 0, 2, 8'h00), "R12 register kept and port restarted");

    // mixed mode
    xfer(cw(1, 0, 0, 0, 8'h03), "R7 enter mixed");
    for (int n = 0; n < 10; n++) begin
      logic [15:0] w;
      w = 16'($urandom);
      w[15] = 1'b0;
      xfer(w, "R9 mixed sample");
    end
    xfer(cw(1, 0, 0, 3, 8'h9E), "R9 mixed control write");
    xfer(cw(0, 0, 0, 3, 8'h11), "R9 bit15 clear is sample");
    xfer(cw(1, 1, 0, 3, 8'h00), "R9 reg3 kept");
    xfer(cw(1, 0, 2, 4, 8'h42), "R9 R4 mixed forward");

    // digital loop-back
    xfer(cw(1, 0, 0, 0, 8'h0B), "R10 enable digital loop-back");
    for (int n = 0; n < 6; n++) begin
      logic [15:0] w;
      w = 16'($urandom);
      w[15] = 1'b0;
      xfer(w, "R10 sample echoed");
    end
    xfer(cw(1, 1, 0, 0, 8'h00), "R10 read mode");

    // serial-port loop-back
    xfer(cw(1, 0, 0, 0, 8'h07), "R11 enable port loop-back");
    xfer(cw(1, 1, 0, 1, 8'h00), "R11 read echoed raw");
    xfer(cw(1, 0, 3, 1, 8'h00), "R11 forward echoed raw");
    xfer(cw(0, 0, 0, 0, 8'h66), "R11 sample echoed raw");
    xfer(cw(1, 0, 0, 4, 8'hD2), "R11 write still applied");
    xfer(cw(1, 0, 0, 0, 8'h03), "R11 leave loop-back");
    xfer(cw(1, 1, 0, 4, 8'h00), "R11 reg4 written under loop-back");

    // data mode: every word is a sample
    xfer(cw(1, 0, 0, 0, 8'h01), "R8 enter data mode");
    xfer(cw(1, 0, 0, 0, 8'h00), "R8 control-looking word is sample");
    xfer(cw(1, 1, 0, 1, 8'h00), "R8 read-looking word is sample");
    for (int n = 0; n < 8; n++) xfer(16'($urandom), "R8 random sample");

    do_reset();
    xfer(cw(1, 1, 0, 0, 8'h00), "R1 mode cleared by reset");
    xfer(cw(1, 0, 0, 5, 8'h81), "R1 program mode after reset");
    xfer(cw(1, 1, 0, 5, 8'h00), "R1 read after reset");

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule